// File: doc/BRIEF.md
# Row Hill Peak Finder

This block watches a stream of smoothed intensity samples, one image row at a time, and picks out narrow bright ridges. It tracks each hill as it goes past: a run of rising samples followed by a run of falling samples, with no turn back upward in between. For every complete hill it measures how far the top stands above the start point, how far it stands above the end point, and how many columns the hill spans. A hill that is tall enough on both sides and narrow enough is reported as one peak. The reported column is the middle of the hill's span, not the column of its highest sample.

Samples arrive with a qualifier, a start-of-row flag and an end-of-row flag. Two threshold inputs, a minimum height and a maximum width, are compared against every hill. The result is a one-cycle strobe with the peak column. The strobe appears on the clock edge after the sample that closes the hill. Grouping peaks across rows is left to later stages.

Top module: `hill_peak_finder`

## Requirements
- R1: While `rst` is high, and after it is released, `peak_valid` is 0. A reset in the middle of a row drops any hill that is being tracked.
- R2: A hill starts at the sample just before the first rise (Ps) and reaches its top at the last sample before the first fall. It ends at the last falling sample (Pe). An accepted hill sets `peak_valid` to 1 for one cycle, on the clock edge that registers the sample that closes it.
- R3: A hill is rejected when its top minus the value at Ps is below `thr_height`. An equal difference is accepted.
- R4: A hill is rejected when its top minus the value at Pe is below `thr_height`.
- R5: A hill is rejected when Pe minus Ps, in columns, is greater than `thr_width`. A width equal to `thr_width` is accepted.
- R6: A sample equal to the one before it never changes the tracking phase. In the middle of a row, an equal sample during the fall does not move Pe.
- R7: A rise that follows a fall closes the current hill and evaluates it. A new hill then starts, with its Ps at the valley sample that the two hills share.
- R8: On the end-of-row sample, a hill that is falling is evaluated with that last sample as Pe. A hill that has only risen is dropped. Tracking then returns to idle.
- R9: A start-of-row sample sets its column to 0, discards any open hill and never produces a peak.
- R10: A cycle with `pix_valid` low is ignored. It does not advance the column, change the stored sample or produce a peak.
- R11: `peak_col` equals (Ps + Pe) >> 1, so an odd sum truncates toward Ps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Sample qualifier |
| pix_sof | input | 1 | This sample is the first of a row (column 0) |
| pix_eor | input | 1 | This sample is the last of a row |
| pix_val | input | DW (8) | Smoothed intensity, unsigned |
| thr_height | input | DW (8) | Minimum height on each side of a hill |
| thr_width | input | CW (6) | Maximum hill span in columns |
| peak_valid | output | 1 | One-cycle strobe for an accepted hill |
| peak_col | output | CW (6) | Midpoint column of the accepted hill |

## Verification
Two things can happen on the same sample. A rise after a fall can close a hill, and the end-of-row flag can force a hill to close. The bench provokes this by ending a row on a rising sample right after a fall. The earlier hill must then be reported with its own Pe, and the new rising hill must be dropped without a second strobe. A second overlap is a falling or flat end-of-row sample. Here Pe must move to the last column, including a flat sample that would not move Pe in the middle of a row.

// File: rtl/hill_pkg.sv
package hill_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RISE = 2'd1,
    ST_FALL = 2'd2
  } hill_st_e;
endpackage

// File: rtl/hill_colcnt.sv
module hill_colcnt #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_valid,
  input  logic          pix_sof,
  output logic [CW-1:0] cur_col,
  output logic [CW-1:0] prev_col
);
  logic [CW-1:0] col_q;

  assign cur_col  = pix_sof ? '0 : col_q + CW'(1);
  assign prev_col = col_q;

  always_ff @(posedge clk) begin
    if (rst) col_q <= '0;
    else if (pix_valid) col_q <= cur_col;
  end
endmodule

// File: rtl/hill_tracker.sv
module hill_tracker
  import hill_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_valid,
  input  logic          pix_sof,
  input  logic          pix_eor,
  input  logic [DW-1:0] pix_val,
  input  logic [CW-1:0] cur_col,
  input  logic [CW-1:0] prev_col,
  output logic          cand_close,
  output logic [CW-1:0] cand_ps,
  output logic [CW-1:0] cand_pe,
  output logic [DW-1:0] cand_psv,
  output logic [DW-1:0] cand_pk,
  output logic [DW-1:0] cand_pev
);
  hill_st_e      st_q, st_d;
  logic [DW-1:0] prev_q, psv_q, psv_d, pk_q, pk_d, pev_q, pev_d;
  logic [CW-1:0] ps_q, ps_d, pe_q, pe_d;
  logic          rise, fall;

  assign rise = pix_val > prev_q;
  assign fall = pix_val < prev_q;

  always_comb begin
    st_d  = st_q;
    ps_d  = ps_q;
    psv_d = psv_q;
    pk_d  = pk_q;
    pe_d  = pe_q;
    pev_d = pev_q;
    cand_close = 1'b0;
    cand_ps  = ps_q;
    cand_psv = psv_q;
    cand_pk  = pk_q;
    cand_pe  = pe_q;
    cand_pev = pev_q;
    if (pix_valid) begin
      if (pix_sof) begin
        st_d = ST_IDLE;
      end else begin
        unique case (st_q)
          ST_IDLE: if (rise) begin
            st_d  = ST_RISE;
            ps_d  = prev_col;
            psv_d = prev_q;
          end
          ST_RISE: if (fall) begin
            st_d  = ST_FALL;
            pk_d  = prev_q;
            pe_d  = cur_col;
            pev_d = pix_val;
          end
          ST_FALL: if (fall) begin
            pe_d  = cur_col;
            pev_d = pix_val;
          end else if (rise) begin
            cand_close = 1'b1;
            st_d  = ST_RISE;
            ps_d  = prev_col;
            psv_d = prev_q;
          end
          default: st_d = ST_IDLE;
        endcase
        if (pix_eor) begin
          if (st_d == ST_FALL) begin
            cand_close = 1'b1;
            cand_ps  = ps_d;
            cand_psv = psv_d;
            cand_pk  = pk_d;
            cand_pe  = cur_col;
            cand_pev = pix_val;
          end
          st_d = ST_IDLE;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      prev_q <= '0;
      ps_q   <= '0;
      psv_q  <= '0;
      pk_q   <= '0;
      pe_q   <= '0;
      pev_q  <= '0;
    end else begin
      st_q  <= st_d;
      ps_q  <= ps_d;
      psv_q <= psv_d;
      pk_q  <= pk_d;
      pe_q  <= pe_d;
      pev_q <= pev_d;
      if (pix_valid) prev_q <= pix_val;
    end
  end
endmodule

// File: rtl/hill_judge.sv
module hill_judge #(
  parameter int DW = 8,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cand_close,
  input  logic [CW-1:0] cand_ps,
  input  logic [CW-1:0] cand_pe,
  input  logic [DW-1:0] cand_psv,
  input  logic [DW-1:0] cand_pk,
  input  logic [DW-1:0] cand_pev,
  input  logic [DW-1:0] thr_height,
  input  logic [CW-1:0] thr_width,
  output logic          peak_valid,
  output logic [CW-1:0] peak_col
);
  logic [DW-1:0] left_h, right_h;
  logic [CW-1:0] span;
  logic          accept;

  assign left_h  = cand_pk - cand_psv;
  assign right_h = cand_pk - cand_pev;
  assign span    = cand_pe - cand_ps;
  assign accept  = cand_close && (left_h >= thr_height) &&
                   (right_h >= thr_height) && (span <= thr_width);

  always_ff @(posedge clk) begin
    if (rst) begin
      peak_valid <= 1'b0;
      peak_col   <= '0;
    end else begin
      peak_valid <= accept;
      if (accept) peak_col <= cand_ps + (span >> 1);
    end
  end
endmodule

// File: rtl/hill_peak_finder.sv
module hill_peak_finder #(
  parameter int DW       = 8,
  parameter int MAX_COLS = 64,
  localparam int CW      = $clog2(MAX_COLS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_valid,
  input  logic          pix_sof,
  input  logic          pix_eor,
  input  logic [DW-1:0] pix_val,
  input  logic [DW-1:0] thr_height,
  input  logic [CW-1:0] thr_width,
  output logic          peak_valid,
  output logic [CW-1:0] peak_col
);
  logic [CW-1:0] cur_col, prev_col, cand_ps, cand_pe;
  logic [DW-1:0] cand_psv, cand_pk, cand_pev;
  logic          cand_close;

  hill_colcnt #(.CW(CW)) u_col (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_sof(pix_sof),
    .cur_col(cur_col), .prev_col(prev_col)
  );

  hill_tracker #(.DW(DW), .CW(CW)) u_trk (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_sof(pix_sof),
    .pix_eor(pix_eor), .pix_val(pix_val), .cur_col(cur_col),
    .prev_col(prev_col), .cand_close(cand_close), .cand_ps(cand_ps),
    .cand_pe(cand_pe), .cand_psv(cand_psv), .cand_pk(cand_pk),
    .cand_pev(cand_pev)
  );

  hill_judge #(.DW(DW), .CW(CW)) u_jdg (
    .clk(clk), .rst(rst), .cand_close(cand_close), .cand_ps(cand_ps),
    .cand_pe(cand_pe), .cand_psv(cand_psv), .cand_pk(cand_pk),
    .cand_pev(cand_pev), .thr_height(thr_height), .thr_width(thr_width),
    .peak_valid(peak_valid), .peak_col(peak_col)
  );
endmodule

// File: rtl/hill_peak_finder_chk.sv
module hill_peak_finder_chk #(
  parameter int DW = 8,
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          pix_valid,
  input logic          pix_sof,
  input logic [DW-1:0] thr_height,
  input logic [CW-1:0] thr_width,
  input logic          cand_close,
  input logic [CW-1:0] cand_ps,
  input logic [CW-1:0] cand_pe,
  input logic [DW-1:0] cand_psv,
  input logic [DW-1:0] cand_pk,
  input logic [DW-1:0] cand_pev,
  input logic          peak_valid,
  input logic [CW-1:0] peak_col
);
  // R10
  idle_cycle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |=> !peak_valid);

  // R9
  row_start_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && pix_sof) |=> !peak_valid);

  // R3
  left_height_ok_chk: assert property (@(posedge clk) disable iff (rst)
    peak_valid |-> ($past(cand_pk - cand_psv) >= $past(thr_height)));

  // R4
  right_height_ok_chk: assert property (@(posedge clk) disable iff (rst)
    peak_valid |-> ($past(cand_pk - cand_pev) >= $past(thr_height)));

  // R5
  span_limit_ok_chk: assert property (@(posedge clk) disable iff (rst)
    peak_valid |-> ($past(cand_pe - cand_ps) <= $past(thr_width)));

  // R11
  mid_inside_span_chk: assert property (@(posedge clk) disable iff (rst)
    peak_valid |-> (peak_col >= $past(cand_ps)) && (peak_col < $past(cand_pe)));

  // R2
  close_has_extent_chk: assert property (@(posedge clk) disable iff (rst)
    cand_close |-> (cand_pe > cand_ps));
endmodule

bind hill_peak_finder hill_peak_finder_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_sof(pix_sof),
  .thr_height(thr_height), .thr_width(thr_width), .cand_close(cand_close),
  .cand_ps(cand_ps), .cand_pe(cand_pe), .cand_psv(cand_psv),
  .cand_pk(cand_pk), .cand_pev(cand_pev), .peak_valid(peak_valid),
  .peak_col(peak_col)
);

// File: tb/hill_peak_finder_test.sv
`timescale 1ns/1ps
module hill_peak_finder_test;
  localparam int DW = 8;
  localparam int CW = 6;
  localparam int NV = 40;

  // entry: {vld, sof, eor, val[7:0], exp_valid, exp_col[5:0]}
  localparam logic [17:0] VEC [NV] = '{
    // row A: accepted hill closed by a rise, then right height too small
    {3'b110, 8'd5,   1'b0, 6'd0}, {3'b100, 8'd20,  1'b0, 6'd0},
    {3'b100, 8'd40,  1'b0, 6'd0}, {3'b100, 8'd30,  1'b0, 6'd0},
    {3'b100, 8'd10,  1'b0, 6'd0}, {3'b100, 8'd50,  1'b1, 6'd2},
    {3'b100, 8'd45,  1'b0, 6'd0}, {3'b101, 8'd44,  1'b0, 6'd0},
    // row B: low left side, then plateau hill of width exactly 6
    {3'b110, 8'd100, 1'b0, 6'd0}, {3'b100, 8'd105, 1'b0, 6'd0},
    {3'b100, 8'd90,  1'b0, 6'd0}, {3'b100, 8'd95,  1'b0, 6'd0},
    {3'b100, 8'd120, 1'b0, 6'd0}, {3'b100, 8'd120, 1'b0, 6'd0},
    {3'b100, 8'd100, 1'b0, 6'd0}, {3'b100, 8'd100, 1'b0, 6'd0},
    {3'b101, 8'd99,  1'b1, 6'd5},
    // row C: width 7 rejected
    {3'b110, 8'd0,   1'b0, 6'd0}, {3'b100, 8'd10,  1'b0, 6'd0},
    {3'b100, 8'd20,  1'b0, 6'd0}, {3'b100, 8'd30,  1'b0, 6'd0},
    {3'b100, 8'd40,  1'b0, 6'd0}, {3'b100, 8'd30,  1'b0, 6'd0},
    {3'b100, 8'd20,  1'b0, 6'd0}, {3'b101, 8'd10,  1'b0, 6'd0},
    // row D: idle cycle inside, flat end-of-row sample, odd midpoint
    {3'b110, 8'd0,   1'b0, 6'd0}, {3'b100, 8'd50,  1'b0, 6'd0},
    {3'b000, 8'd200, 1'b0, 6'd0}, {3'b100, 8'd0,   1'b0, 6'd0},
    {3'b101, 8'd0,   1'b1, 6'd1},
    // row E: rise and end of row on the same sample
    {3'b110, 8'd10,  1'b0, 6'd0}, {3'b100, 8'd40,  1'b0, 6'd0},
    {3'b100, 8'd20,  1'b0, 6'd0}, {3'b101, 8'd60,  1'b1, 6'd1},
    // row F: open hill discarded by a new row start
    {3'b110, 8'd0,   1'b0, 6'd0}, {3'b100, 8'd80,  1'b0, 6'd0},
    {3'b100, 8'd20,  1'b0, 6'd0}, {3'b110, 8'd10,  1'b0, 6'd0},
    {3'b100, 8'd10,  1'b0, 6'd0}, {3'b101, 8'd10,  1'b0, 6'd0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pix_valid = 1'b0, pix_sof = 1'b0, pix_eor = 1'b0;
  logic [DW-1:0] pix_val = '0;
  logic [DW-1:0] thr_height = 8'd10;
  logic [CW-1:0] thr_width = 6'd6;
  logic          peak_valid;
  logic [CW-1:0] peak_col;
  int            n_checks = 0;
  int            n_fails  = 0;

  always #2 clk = ~clk;

  hill_peak_finder uut (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_sof(pix_sof),
    .pix_eor(pix_eor), .pix_val(pix_val), .thr_height(thr_height),
    .thr_width(thr_width), .peak_valid(peak_valid), .peak_col(peak_col)
  );

  function automatic string tag_of(input int idx);
    if (idx < 8)  return "R2 R4 R7";
    if (idx < 17) return "R3 R5 R6 R8";
    if (idx < 25) return "R5";
    if (idx < 30) return "R8 R10 R11";
    if (idx < 34) return "R7 R8";
    return "R9";
  endfunction

  task automatic send(input logic v, input logic s, input logic e, input logic [DW-1:0] d);
    @(negedge clk);
    pix_valid = v; pix_sof = s; pix_eor = e; pix_val = d;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic ev, input logic [CW-1:0] ec);
    n_checks++;
    if (peak_valid !== ev || (ev && peak_col !== ec)) begin
      n_fails++;
      $display("FAIL %s: peak_valid=%0d peak_col=%0d expected valid=%0d col=%0d",
               req, peak_valid, peak_col, ev, ec);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 in reset", 1'b0, '0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][17], VEC[i][16], VEC[i][15], VEC[i][14:7]);
      check(tag_of(i), VEC[i][6], VEC[i][5:0]);
    end

    // R3: left height of exactly the threshold is accepted
    thr_height = 8'd1; thr_width = 6'd63;
    send(1'b1, 1'b1, 1'b0, 8'd7); check("R3", 1'b0, '0);
    send(1'b1, 1'b0, 1'b0, 8'd8); check("R3", 1'b0, '0);
    send(1'b1, 1'b0, 1'b1, 8'd7); check("R3 equal height", 1'b1, 6'd1);
    // R3: same hill with threshold 2 is rejected
    thr_height = 8'd2;
    send(1'b1, 1'b1, 1'b0, 8'd7); check("R3", 1'b0, '0);
    send(1'b1, 1'b0, 1'b0, 8'd8); check("R3", 1'b0, '0);
    send(1'b1, 1'b0, 1'b1, 8'd7); check("R3 short left", 1'b0, '0);

    // R1: reset in the middle of a falling hill drops it
    thr_height = 8'd10; thr_width = 6'd6;
    send(1'b1, 1'b1, 1'b0, 8'd0);
    send(1'b1, 1'b0, 1'b0, 8'd90);
    send(1'b1, 1'b0, 1'b0, 8'd10);
    @(negedge clk); rst = 1'b1; pix_valid = 1'b0;
    @(posedge clk); #1;
    check("R1 after mid-row reset", 1'b0, '0);
    @(negedge clk); rst = 1'b0;
    send(1'b1, 1'b0, 1'b1, 8'd5); check("R1 hill dropped", 1'b0, '0);

    @(negedge clk); pix_valid = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule